// File: doc/BRIEF.md
# Masked VLIW Instruction Expander

This block turns a compact instruction stream back into full-width very long instruction words. Memory holds each wide instruction as one presence word followed only by the operation words that are really there. The block takes these 32-bit words one at a time over a valid/ready input. It places each operation word in its own slot of a 1024-bit instruction, which has 32 slots of 32 bits each. It then offers the finished instruction on a valid/ready output.

Slots that the presence word marks as empty come out as the all-zero no-operation code. Because of this packing, an instruction with few busy slots takes only a few memory words. The execution stage still always sees a fixed-format word with one field for each unit.

Top module: `vliw_expander`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, and the next accepted input word is taken as a presence word.
- R2: Bit i of the presence word (bit 0 = least significant) marks slot i as occupied. The operation words that follow are placed into occupied slots in ascending slot order. Slot i appears on `out_instr[32*i+31 : 32*i]`.
- R3: Every slot whose presence bit is 0 is output as 32'h0000_0000, whatever the previous instruction held in that slot.
- R4: One instruction consumes exactly 1 + (number of set presence bits) accepted words. `out_valid` is 1 in the cycle right after the last of these words is accepted, and not before. The next accepted word is a new presence word.
- R5: A presence word of 0 gives an instruction with every slot 0. `out_valid` is 1 in the cycle right after that presence word is accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_instr` is unchanged and `in_ready` is 0. Input words offered during that time are not consumed.
- R7: A presence word of 32'hFFFF_FFFF takes 32 operation words and fills every slot with them in order.
- R8: Reset in the middle of an instruction drops the words already collected. The next accepted word is a presence word.
- R9: A cycle with `in_valid` at 0 changes nothing, whatever value `in_data` has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Presence word or packed operation word |
| out_valid | output | 1 | Expanded instruction is ready |
| out_ready | input | 1 | Consumer takes the instruction |
| out_instr | output | 1024 | Expanded instruction, slot i at bits 32*i+31:32*i |

## Verification
The bench targets the count of words that follow a presence word. A design that counts wrongly either raises `out_valid` one word early or late, or takes the next presence word as an operation; a sparse mask followed by an immediate second instruction exposes both. A fully busy instruction followed by a sparse one shows whether unused slots keep stale data instead of the zero code. The all-zero mask, a long output stall with junk offered at the input, and a reset halfway through an instruction each check that no word is lost, taken twice, or left over in the next instruction.

// File: rtl/vliw_exp_pkg.sv
package vliw_exp_pkg;

    typedef enum logic [1:0] {
        ST_MASK = 2'd0,
        ST_OPS  = 2'd1,
        ST_HOLD = 2'd2
    } exp_state_e;

endpackage

// File: rtl/vliw_exp_lowbit.sv
module vliw_exp_lowbit #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/vliw_exp_slotfile.sv
module vliw_exp_slotfile #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 32,
    localparam int IW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_all,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_idx,
    input  logic [SLOT_W-1:0]           wr_data,
    output logic [NUM_SLOTS*SLOT_W-1:0] flat
);

    logic [NUM_SLOTS-1:0] hit;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [SLOT_W-1:0] slot_d, slot_q;

        assign hit[s] = wr_en && (wr_idx == IW'(s));

        always_comb begin
            slot_d = slot_q;
            if (clr_all)     slot_d = '0;
            else if (hit[s]) slot_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q <= '0;
            else     slot_q <= slot_d;
        end

        assign flat[s*SLOT_W +: SLOT_W] = slot_q;
    end

    AST_ONE_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R2

    AST_CLEAR_TO_NOP: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_en) |=> (flat == '0)); // R3

endmodule

// File: rtl/vliw_expander.sv
module vliw_expander
    import vliw_exp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 32,
    localparam int IW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int INSTR_W  = NUM_SLOTS * SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SLOT_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr
);

    typedef struct packed {
        exp_state_e           state;
        logic [NUM_SLOTS-1:0] remain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 in_fire;
    logic                 clr_all;
    logic                 wr_en;
    logic [IW-1:0]        low_idx;
    logic                 low_any;
    logic [NUM_SLOTS-1:0] mask_in;

    assign mask_in = in_data[NUM_SLOTS-1:0];

    vliw_exp_lowbit #(.N(NUM_SLOTS)) lowbit_i (
        .vec (ctl_q.remain),
        .idx (low_idx),
        .any (low_any)
    );

    always_comb begin
        ctl_d     = ctl_q;
        clr_all   = 1'b0;
        wr_en     = 1'b0;
        in_ready  = (ctl_q.state != ST_HOLD);
        out_valid = (ctl_q.state == ST_HOLD);
        in_fire   = in_valid && in_ready;
        unique case (ctl_q.state)
            ST_MASK: begin
                if (in_fire) begin
                    clr_all      = 1'b1;
                    ctl_d.remain = mask_in;
                    ctl_d.state  = (mask_in == '0) ? ST_HOLD : ST_OPS;
                end
            end
            ST_OPS: begin
                if (in_fire && low_any) begin
                    wr_en        = 1'b1;
                    ctl_d.remain = ctl_q.remain & (ctl_q.remain - 1'b1);
                    if (ctl_d.remain == '0) ctl_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (out_ready) ctl_d.state = ST_MASK;
            end
            default: ctl_d.state = ST_MASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state  <= ST_MASK;
            ctl_q.remain <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    vliw_exp_slotfile #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) slots_i (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .wr_en   (wr_en),
        .wr_idx  (low_idx),
        .wr_data (in_data),
        .flat    (out_instr)
    );

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_instr))); // R6

    AST_NO_INPUT_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R6

    AST_ZERO_MASK_DONE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_MASK && in_valid && mask_in == '0) |=> out_valid); // R5

    AST_ONE_BIT_PER_WORD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_OPS && in_valid) |=>
        ($countones(ctl_q.remain) == $countones($past(ctl_q.remain)) - 1)); // R4

    AST_LAST_WORD_DONE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_OPS && in_valid && $countones(ctl_q.remain) == 1) |=> out_valid); // R4

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> $stable(ctl_q.remain)); // R9

endmodule

// File: tb/vliw_expander_tb_top.sv
module vliw_expander_tb_top;

    localparam int NS = 32;
    localparam int SW = 32;
    localparam int IWD = NS * SW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [SW-1:0]  in_data = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [IWD-1:0] out_instr;

    int n_chk = 0;
    int n_bad = 0;

    logic [SW-1:0] ops [NS];

    always #5 clk = ~clk;

    vliw_expander dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_instr (out_instr)
    );

    task automatic chk(string req, logic [IWD-1:0] act, logic [IWD-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [IWD-1:0] expand(logic [SW-1:0] m);
        logic [IWD-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < NS; i++) begin
            if (m[i]) begin
                r[i*SW +: SW] = ops[k];
                k++;
            end
        end
        return r;
    endfunction

    // entered and left at a falling edge
    task automatic push(logic [SW-1:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hDEAD_BEEF;
    endtask

    task automatic send(logic [SW-1:0] m, int gap);
        int cnt = $countones(m);
        push(m);
        for (int k = 0; k < cnt; k++) begin
            chk("R4 early valid", IWD'(out_valid), IWD'(0));
            repeat (gap) @(negedge clk);
            push(ops[k]);
        end
    endtask

    task automatic take(string req, logic [SW-1:0] m);
        chk({req, " valid"}, IWD'(out_valid), IWD'(1));
        chk({req, " data"}, out_instr, expand(m));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({req, " released"}, IWD'({out_valid, in_ready}), IWD'(2'b01));
    endtask

    task automatic fill_ops(logic [SW-1:0] seed);
        for (int i = 0; i < NS; i++) ops[i] = seed ^ (32'h0101_0101 * (i + 1));
    endtask

    task automatic t_reset();
        chk("R1 reset", IWD'({out_valid, in_ready}), IWD'(2'b01));
    endtask

    task automatic t_sparse();
        fill_ops(32'hA5A5_0000);
        send(32'h8000_0011, 0);
        take("R2 R4 sparse", 32'h8000_0011);
        // next word right away must act as a presence word
        send(32'h0000_0005, 0);
        take("R4 back-to-back", 32'h0000_0005);
    endtask

    task automatic t_zero();
        push(32'h0);
        take("R5 zero mask", 32'h0);
    endtask

    task automatic t_full_then_sparse();
        fill_ops(32'h1234_0000);
        send(32'hFFFF_FFFF, 0);
        take("R7 full", 32'hFFFF_FFFF);
        fill_ops(32'h7777_0000);
        send(32'h0000_0002, 0);
        take("R3 stale cleared", 32'h0000_0002);
    endtask

    task automatic t_stall();
        logic [IWD-1:0] snap;
        fill_ops(32'h0F0F_0000);
        send(32'h0001_0100, 0);
        snap = out_instr;
        in_valid = 1'b1;
        in_data  = 32'h0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R6 stall", IWD'({out_valid, in_ready}), IWD'(2'b10));
            chk("R6 stable", out_instr, snap);
        end
        in_valid = 1'b0;
        take("R6 after stall", 32'h0001_0100);
        fill_ops(32'h3C3C_0000);
        send(32'h0000_0003, 0);
        take("R6 nothing consumed", 32'h0000_0003);
    endtask

    task automatic t_gaps();
        fill_ops(32'h5555_0000);
        send(32'h4000_0208, 3);
        take("R9 idle gaps", 32'h4000_0208);
    endtask

    task automatic t_mid_reset();
        fill_ops(32'h9999_0000);
        push(32'h0000_0007);
        push(ops[0]);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset mid", IWD'({out_valid, in_ready}), IWD'(2'b01));
        fill_ops(32'h2468_0000);
        send(32'h0000_0001, 0);
        take("R8 fresh after reset", 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sparse();
        t_zero();
        t_full_then_sparse();
        t_stall();
        t_gaps();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule